// File: doc/BRIEF.md
# Interline CCD Vertical Frame and Shutter Sequencer

This block runs one complete frame of an interline CCD each time it receives a start command. A frame has these phases, in order:

1. An optional set of flush lines. The substrate shutter pulse is placed inside this span.
2. A transfer pulse, which moves charge from the photodiodes to the vertical register.
3. A pedestal.
4. A settle delay.
5. The readout lines that carry image data.

The block drives three vertical phase codes to an external level driver: V1, an even V2 and an odd V2. Each code is 2 bits: 0 = low, 1 = mid, 2 = high. The block pulses a line request at the start of every line so that a horizontal line generator can clock that line out. A qualifier marks the lines that carry image data.

There are three readout styles, chosen by the mode input:

- Progressive readout sends out every row.
- Field-integration interlaced readout sends out half the rows per field. Both V2 phases carry the same waveform.
- Frame-integration interlaced readout also sends out half the rows per field. Only one V2 phase gets the transfer pulse in each field, and the two fields alternate.

The exposure input sets exposure. When it is non-zero, it gives the number of flush lines that come before the transfer. The shutter pulse sits in the first of those lines, so integration runs from the shutter's falling edge to the end of the transfer pulse. An exposure value larger than a frame simply adds more flush lines.

Top module: `ccd_vseq`

## Requirements
- R1: After reset the block is idle. V1 is low (0), both V2 codes are mid (1), and shutter, line_req, line_valid and frame_done are all 0.
- R2: During each line's first VSH cycles, V1 is mid (1) and both V2 codes are low (0). For the rest of the line, V1 is low and V2 is mid. V1 and V2 are never both low, and V1 is low whenever a V2 code is high (2).
- R3: Mode 0 is progressive, and mode 3 behaves the same way. The frame reads ROWS lines. The transfer drives both V2 codes high together for TX cycles.
- R4: Mode 1 is field integration. The frame reads ROWS/2 lines, and the transfer drives both V2 codes high together.
- R5: Mode 2 is frame integration. The frame reads ROWS/2 lines. In the even field only the even V2 goes high during the transfer, and in the odd field only the odd V2 goes high; the other code stays mid. The first field after reset is even. The field toggles after every interlaced frame (mode 1 or 2).
- R6: The transfer is followed by PED cycles of pedestal and then DLY cycles of delay. During both, V1 is low and V2 is mid.
- R7: A non-zero exposure E inserts E flush lines before the transfer. line_valid stays 0 during these lines. The shutter is high in the first flush line, from line cycle SH_DLY for SH_W cycles.
- R8: With exposure 0 there are no flush lines and no shutter pulse. The transfer begins in the first cycle after start is accepted.
- R9: line_req pulses for one cycle at the first cycle of every flush and readout line. line_valid is 1 for exactly the readout lines.
- R10: frame_done pulses for one cycle right after the last readout line. A start that arrives while a frame is in progress is ignored.
- R11: The time from the shutter's falling edge to the first V2 code leaving high is E*LINE_CYC + TX - SH_DLY - SH_W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Readout style, captured at start |
| exposure | input | EW | Flush-line count; 0 disables the shutter |
| start | input | 1 | Begin a frame when idle |
| v1 | output | 2 | V1 level code |
| v2e | output | 2 | Even V2 level code |
| v2o | output | 2 | Odd V2 level code |
| shutter | output | 1 | Substrate shutter pulse |
| line_req | output | 1 | Start-of-line request to the line generator |
| line_valid | output | 1 | Current line carries image data |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check on every cycle:

- the V1/V2 ordering rules;
- that the two V2 codes are equal outside frame-integration mode, and are never both high inside it;
- that the shutter never overlaps an image line;
- that frame_done lasts a single cycle.

Some behaviour can only be shown by the bench scenarios, which sweep every mode against several exposure values:

- the line counts for each mode;
- the alternation of fields;
- the exact place of the shutter and the integration interval;
- that a start arriving mid-frame is ignored.

// File: rtl/ccd_vseq.sv
module ccd_vseq #(
  parameter int ROWS     = 1092,
  parameter int LINE_CYC = 40,
  parameter int VSH      = 4,
  parameter int TX       = 12,
  parameter int PED      = 25,
  parameter int DLY      = 20,
  parameter int SH_DLY   = 2,
  parameter int SH_W     = 5,
  parameter int EW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [EW-1:0] exposure,
  input  logic          start,
  output logic [1:0]    v1,
  output logic [1:0]    v2e,
  output logic [1:0]    v2o,
  output logic          shutter,
  output logic          line_req,
  output logic          line_valid,
  output logic          frame_done
);
  localparam int CW = $clog2(LINE_CYC + TX + PED + DLY + 1) + 1;
  localparam int LW = $clog2(ROWS + (1 << EW)) + 1;
  localparam logic [1:0] LOW = 2'd0, MID = 2'd1, HIGH = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_EXPO, S_XFER, S_PED, S_DLY, S_READ} st_t;

  st_t           st;
  logic [CW-1:0] cyc;
  logic [LW-1:0] line;
  logic [1:0]    mode_q;
  logic [EW-1:0] exp_q;
  logic          field;

  wire          interl   = (mode_q == 2'd1) || (mode_q == 2'd2);
  wire [LW-1:0] nread    = interl ? LW'(ROWS / 2) : LW'(ROWS);
  wire          line_end = cyc == CW'(LINE_CYC - 1);
  wire          in_line  = (st == S_EXPO) || (st == S_READ);
  wire          shift    = in_line && (cyc < CW'(VSH));
  wire          xfer     = st == S_XFER;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cyc <= '0; line <= '0; mode_q <= '0; exp_q <= '0;
      field <= 1'b0; frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      cyc <= cyc + 1'b1;
      case (st)
        S_IDLE: begin
          cyc <= '0;
          if (start) begin
            mode_q <= mode; exp_q <= exposure; line <= '0;
            st <= (exposure != '0) ? S_EXPO : S_XFER;
          end
        end
        S_EXPO: if (line_end) begin
          cyc <= '0;
          if (line == LW'(exp_q) - 1'b1) begin line <= '0; st <= S_XFER; end
          else line <= line + 1'b1;
        end
        S_XFER: if (cyc == CW'(TX - 1))  begin cyc <= '0; st <= S_PED;  end
        S_PED:  if (cyc == CW'(PED - 1)) begin cyc <= '0; st <= S_DLY;  end
        S_DLY:  if (cyc == CW'(DLY - 1)) begin cyc <= '0; st <= S_READ; end
        S_READ: if (line_end) begin
          cyc <= '0;
          if (line == nread - 1'b1) begin
            line <= '0; st <= S_IDLE; frame_done <= 1'b1;
            if (interl) field <= ~field;
          end else line <= line + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign v1  = shift ? MID : LOW;
  assign v2e = xfer ? ((mode_q == 2'd2 && field)  ? MID : HIGH) : (shift ? LOW : MID);
  assign v2o = xfer ? ((mode_q == 2'd2 && !field) ? MID : HIGH) : (shift ? LOW : MID);
  assign shutter    = (st == S_EXPO) && (line == '0) && (cyc >= CW'(SH_DLY)) &&
                      (cyc < CW'(SH_DLY + SH_W));
  assign line_req   = in_line && (cyc == '0);
  assign line_valid = st == S_READ;

  AST_V_NOT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1 == LOW && (v2e == LOW || v2o == LOW))); // R2
  AST_V1_LOW_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (v2e == HIGH || v2o == HIGH) |-> v1 == LOW); // R2
  AST_V2_TWINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd2) |-> v2e == v2o); // R3
  AST_FRAME_INT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> !(v2e == HIGH && v2o == HIGH)); // R5
  AST_SHUT_NOT_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> !line_valid); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R10
endmodule

// File: tb/ccd_vseq_tb_top.sv
module ccd_vseq_tb_top;
  localparam int ROWS = 6, L = 8, VSH = 2, TX = 3, PED = 2, DLY = 2, SD = 1, SW = 2, EW = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [EW-1:0] exposure = '0;
  logic [1:0] v1, v2e, v2o;
  logic shutter, line_req, line_valid, frame_done;
  int checks = 0, fails = 0, cycles = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  ccd_vseq #(.ROWS(ROWS), .LINE_CYC(L), .VSH(VSH), .TX(TX), .PED(PED), .DLY(DLY),
             .SH_DLY(SD), .SH_W(SW), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .exposure(exposure), .start(start),
    .v1(v1), .v2e(v2e), .v2o(v2o), .shutter(shutter), .line_req(line_req),
    .line_valid(line_valid), .frame_done(frame_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] expv(int md, int e, int fld, int k);
    int n = (md == 1 || md == 2) ? ROWS / 2 : ROWS;
    int t0 = e * L, t1 = t0 + TX, t3 = t1 + PED + DLY, t4 = t3 + n * L;
    logic [1:0] a1 = 2'd0, ae = 2'd1, ao = 2'd1;
    logic sh = 0, rq = 0, vl = 0, dn = 0;
    if (k < t0) begin
      if (k % L < VSH) begin a1 = 2'd1; ae = 2'd0; ao = 2'd0; end
      rq = (k % L == 0);
      sh = (k >= SD && k < SD + SW);
    end else if (k < t1) begin
      ae = (md == 2 && fld == 1) ? 2'd1 : 2'd2;
      ao = (md == 2 && fld == 0) ? 2'd1 : 2'd2;
    end else if (k < t3) begin
    end else if (k < t4) begin
      if ((k - t3) % L < VSH) begin a1 = 2'd1; ae = 2'd0; ao = 2'd0; end
      rq = ((k - t3) % L == 0);
      vl = 1;
    end else if (k == t4) dn = 1;
    return {a1, ae, ao, sh, rq, vl, dn};
  endfunction

  function automatic string tag_of(int md, int e, int k);
    int n = (md == 1 || md == 2) ? ROWS / 2 : ROWS;
    int t0 = e * L, t1 = t0 + TX, t3 = t1 + PED + DLY, t4 = t3 + n * L;
    if (k < t0) return "R7 flush/shutter";
    if (k < t1) return (e == 0) ? "R8 immediate transfer" :
                       (md == 2) ? "R5 frame-int transfer" :
                       (md == 1) ? "R4 field-int transfer" : "R3 progressive transfer";
    if (k < t3) return "R6 pedestal/delay";
    if (k < t4) return (md == 0 || md == 3) ? "R9 R3 readout" : "R9 R4 R5 readout";
    return "R10 frame_done";
  endfunction

  int field = 0;

  task automatic run_frame(input int md, input int e);
    int n = (md == 1 || md == 2) ? ROWS / 2 : ROWS;
    int t4 = e * L + TX + PED + DLY + n * L;
    int sh_fall = -1, v2_fall = -1;
    logic prev_sh = 0, prev_hi = 0;
    mode = 2'(md); exposure = EW'(e); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= t4 + 1; k++) begin
      logic [10:0] got = {v1, v2e, v2o, shutter, line_req, line_valid, frame_done};
      logic [10:0] want = (k <= t4) ? expv(md, e, field, k) : 11'b00_01_01_0000;
      logic hi = (v2e == 2'd2) || (v2o == 2'd2);
      chk(got == want, (k <= t4) ? tag_of(md, e, k) : "R10 idle after done",
          int'(got), int'(want));
      if (prev_sh && !shutter && sh_fall < 0) sh_fall = k;
      if (prev_hi && !hi && v2_fall < 0) v2_fall = k;
      prev_sh = shutter; prev_hi = hi;
      start = (k == 4 || k == 5) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (e > 0)
      chk(v2_fall - sh_fall == e * L + TX - SD - SW, "R11 integration interval",
          v2_fall - sh_fall, e * L + TX - SD - SW);
    if (md == 1 || md == 2) field ^= 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({v1, v2e, v2o, shutter, line_req, line_valid, frame_done} == 11'b00_01_01_0000,
        "R1 reset state", int'({v1, v2e, v2o, shutter, line_req, line_valid, frame_done}),
        11'b00_01_01_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({v1, v2e, v2o, shutter, line_req, line_valid, frame_done} == 11'b00_01_01_0000,
        "R1 idle after reset", int'({v1, v2e, v2o, shutter, line_req, line_valid, frame_done}),
        11'b00_01_01_0000);
    for (int md = 0; md < 4; md++) begin
      run_frame(md, 0);
      run_frame(md, 1);
      run_frame(md, 2);
      run_frame(md, 7);
    end
    run_frame(2, 0);
    run_frame(2, 3);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule